// File: doc/BRIEF.md
# Streaming Coefficient Quantizer

This block takes a stream of signed transform coefficients, grouped in blocks of 64, and divides each one by a step size taken from one of two built-in quantization tables. Coefficients arrive one per cycle when `in_valid` is high. Idle cycles may fall anywhere inside a block. Each quotient leaves on `out_quot` with its own `out_valid` strobe, a fixed number of cycles later and in the order the coefficients arrived.

A 2-bit component code on `comp_sel` selects the table. Codes for the two brightness components pick the brightness table. Codes for the two colour-difference components pick the colour table. The code is captured on the first beat of each block and held until that block's 64th beat. Both tables are generated at elaboration into one 128-entry lookup. The divide is a pipelined restoring divider that rounds to nearest.

A two-state sequencer controls block tracking. `SEQ_IDLE` waits for the first beat of a block. On that beat it captures the table, goes to `SEQ_BLOCK` and sets the beat counter to 1. `SEQ_BLOCK` counts the beats. On a valid beat at position 63 it goes back to `SEQ_IDLE`, and on any other valid beat it stays in `SEQ_BLOCK`. In both states a cycle without `in_valid` leaves the state and the counter unchanged.

Top module: `coef_quantizer`

## Requirements
- R1: While `rst_n` is low, `out_valid` and `out_quot` are 0. After reset, the next valid beat is position 0 of a new block.
- R2: On the first beat of a block, component codes 0 and 1 select table 0, and codes 2 and 3 select table 1.
- R3: The table captured on the first beat is used for all 64 beats of the block. Changes on `comp_sel` during the block have no effect.
- R4: A block is exactly 64 valid beats. The 65th valid beat starts a new block and samples `comp_sel` again.
- R5: For beat position i, with r = i / 8 and c = i mod 8, the table 0 entry is 4r + 5c and the table 1 entry is 17r + 19c + 1. The lookup address is i + 64 × table.
- R6: The quotient magnitude is floor((2|a| + d) / (2d)), which is round to nearest with ties away from zero. The sign of the quotient is the sign of the dividend.
- R7: A divisor of 0 gives a quotient of 0.
- R8: A result appears on the outputs after the sixth rising edge, counting the edge that samples the input. Idle input cycles show up as the same idle output cycles.
- R9: `out_quot` is 0 on every cycle where `out_valid` is low.
- R10: Coefficients from -2048 to 2047 are quantized without overflow. The extremes with divisor 1 give -2048 and 2047.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Marks a coefficient beat |
| in_coef | input | 12 | Signed coefficient |
| comp_sel | input | 2 | Component code, sampled on the first beat of a block |
| out_valid | output | 1 | Marks a quotient beat |
| out_quot | output | 12 | Signed rounded quotient |

## Verification
The bound checker checks the sequencer on every cycle: the capture of the table on the first beat (R2), the hold of the table during a block (R3), the single-step beat counter and the return to idle after 64 beats (R4), and the zero output on idle cycles (R9). It also tracks the number of beats in flight, so a valid output with no matching input, or too many beats in the pipeline, is flagged (R8). The bench must show everything that depends on the values: the table entries, the rounding of ties, the zero divisor, the extreme inputs and the exact latency through gaps. It does this by comparing against a behavioural model on every clock.

// File: rtl/cq_pkg.sv
package cq_pkg;

    typedef enum logic [0:0] {
        SEQ_IDLE  = 1'b0,
        SEQ_BLOCK = 1'b1
    } seq_state_e;

    // Step size for table tbl at block position idx (8 x 8 layout)
    function automatic int step_entry(input int tbl, input int idx);
        int r;
        int c;
        r = idx / 8;
        c = idx % 8;
        if (tbl == 0) begin
            return 4 * r + 5 * c;
        end
        return 17 * r + 19 * c + 1;
    endfunction

endpackage

// File: rtl/cq_step_rom.sv
module cq_step_rom #(
    parameter int DIV_W   = 8,
    parameter int BLK_LEN = 64,
    parameter int ADDR_W  = 7
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [DIV_W-1:0]  step
);
    localparam int DEPTH = 2 * BLK_LEN;

    logic [DIV_W-1:0] entry [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        assign entry[g] = DIV_W'(cq_pkg::step_entry(g / BLK_LEN, g % BLK_LEN));
    end

    assign step = entry[addr];
endmodule

// File: rtl/cq_block_seq.sv
module cq_block_seq #(
    parameter int BLK_LEN = 64,
    parameter int IDX_W   = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [1:0]       comp_sel,
    output logic [IDX_W-1:0] cur_idx,
    output logic             cur_tbl,
    output logic             busy,
    output logic             held_tbl
);
    import cq_pkg::*;

    localparam logic [IDX_W-1:0] LAST = IDX_W'(BLK_LEN - 1);

    seq_state_e       state_q, state_n;
    logic [IDX_W-1:0] cnt_q, cnt_n;
    logic             tbl_q, tbl_n;
    logic             code_is_chroma;

    assign code_is_chroma = (comp_sel >= 2'd2);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
            tbl_q   <= 1'b0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
            tbl_q   <= tbl_n;
        end
    end

    // next state and outputs
    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        tbl_n   = tbl_q;
        cur_idx = cnt_q;
        cur_tbl = tbl_q;
        busy    = 1'b0;
        unique case (state_q)
            SEQ_IDLE: begin
                cur_idx = '0;
                cur_tbl = code_is_chroma;
                if (in_valid) begin
                    tbl_n   = code_is_chroma;
                    cnt_n   = IDX_W'(1);
                    state_n = SEQ_BLOCK;
                end
            end
            SEQ_BLOCK: begin
                busy = 1'b1;
                if (in_valid) begin
                    if (cnt_q == LAST) begin
                        cnt_n   = '0;
                        state_n = SEQ_IDLE;
                    end else begin
                        cnt_n = cnt_q + 1'b1;
                    end
                end
            end
            default: begin
                state_n = SEQ_IDLE;
            end
        endcase
    end

    assign held_tbl = tbl_q;
endmodule

// File: rtl/cq_div_pipe.sv
module cq_div_pipe #(
    parameter int NUM_W  = 13,
    parameter int DEN_W  = 9,
    parameter int Q_W    = 12,
    parameter int BPS    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             i_vld,
    input  logic [NUM_W-1:0] i_num,
    input  logic [DEN_W-1:0] i_den,
    input  logic             i_neg,
    input  logic             i_dz,
    output logic             o_vld,
    output logic [Q_W-1:0]   o_mag,
    output logic             o_neg,
    output logic             o_dz
);
    localparam int STAGES = (NUM_W + BPS - 1) / BPS;
    localparam int PAD_W  = STAGES * BPS;
    localparam int REM_W  = DEN_W + 1;

    logic [PAD_W-1:0] nq_s  [STAGES+1];
    logic [REM_W-1:0] rem_s [STAGES+1];
    logic [DEN_W-1:0] den_s [STAGES+1];
    logic             vld_s [STAGES+1];
    logic             neg_s [STAGES+1];
    logic             dz_s  [STAGES+1];

    assign nq_s[0]  = PAD_W'(i_num);
    assign rem_s[0] = '0;
    assign den_s[0] = i_den;
    assign vld_s[0] = i_vld;
    assign neg_s[0] = i_neg;
    assign dz_s[0]  = i_dz;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        logic [PAD_W-1:0] nq_t;
        logic [REM_W-1:0] rem_t;

        always_comb begin
            nq_t  = nq_s[g];
            rem_t = rem_s[g];
            for (int b = 0; b < BPS; b++) begin
                rem_t = {rem_t[REM_W-2:0], nq_t[PAD_W-1]};
                nq_t  = {nq_t[PAD_W-2:0], 1'b0};
                if (rem_t >= REM_W'(den_s[g])) begin
                    rem_t    = rem_t - REM_W'(den_s[g]);
                    nq_t[0]  = 1'b1;
                end
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                nq_s[g+1]  <= '0;
                rem_s[g+1] <= '0;
                den_s[g+1] <= '0;
                vld_s[g+1] <= 1'b0;
                neg_s[g+1] <= 1'b0;
                dz_s[g+1]  <= 1'b0;
            end else begin
                nq_s[g+1]  <= nq_t;
                rem_s[g+1] <= rem_t;
                den_s[g+1] <= den_s[g];
                vld_s[g+1] <= vld_s[g];
                neg_s[g+1] <= neg_s[g];
                dz_s[g+1]  <= dz_s[g];
            end
        end
    end

    assign o_vld = vld_s[STAGES];
    assign o_mag = nq_s[STAGES][Q_W-1:0];
    assign o_neg = neg_s[STAGES];
    assign o_dz  = dz_s[STAGES];
endmodule

// File: rtl/coef_quantizer.sv
module coef_quantizer #(
    parameter int COEF_W  = 12,
    parameter int DIV_W   = 8,
    parameter int BLK_LEN = 64,
    parameter int BPS     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [COEF_W-1:0] in_coef,
    input  logic [1:0]        comp_sel,
    output logic              out_valid,
    output logic [COEF_W-1:0] out_quot
);
    localparam int IDX_W   = $clog2(BLK_LEN);
    localparam int ADDR_W  = IDX_W + 1;
    localparam int NUM_W   = COEF_W + 1;
    localparam int DEN_W   = DIV_W + 1;
    localparam int STAGES  = (NUM_W + BPS - 1) / BPS;
    localparam int LATENCY = STAGES + 2;

    logic [IDX_W-1:0] seq_idx;
    logic             seq_tbl;
    logic             seq_busy;
    logic             seq_tbl_held;
    logic [DIV_W-1:0] step;

    cq_block_seq #(.BLK_LEN(BLK_LEN), .IDX_W(IDX_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .comp_sel (comp_sel),
        .cur_idx  (seq_idx),
        .cur_tbl  (seq_tbl),
        .busy     (seq_busy),
        .held_tbl (seq_tbl_held)
    );

    cq_step_rom #(.DIV_W(DIV_W), .BLK_LEN(BLK_LEN), .ADDR_W(ADDR_W)) u_rom (
        .addr (ADDR_W'({seq_tbl, seq_idx})),
        .step (step)
    );

    // operand preparation stage
    logic [COEF_W-1:0] mag_in;
    logic              a_vld, a_neg, a_dz;
    logic [NUM_W-1:0]  a_num;
    logic [DEN_W-1:0]  a_den;

    assign mag_in = in_coef[COEF_W-1] ? COEF_W'(-in_coef) : in_coef;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_vld <= 1'b0;
            a_neg <= 1'b0;
            a_dz  <= 1'b0;
            a_num <= '0;
            a_den <= '0;
        end else begin
            a_vld <= in_valid;
            a_neg <= in_coef[COEF_W-1];
            a_dz  <= (step == '0);
            a_num <= {mag_in, 1'b0} + NUM_W'(step);
            a_den <= {step, 1'b0};
        end
    end

    logic              d_vld, d_neg, d_dz;
    logic [COEF_W-1:0] d_mag;

    cq_div_pipe #(.NUM_W(NUM_W), .DEN_W(DEN_W), .Q_W(COEF_W), .BPS(BPS)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .i_vld (a_vld),
        .i_num (a_num),
        .i_den (a_den),
        .i_neg (a_neg),
        .i_dz  (a_dz),
        .o_vld (d_vld),
        .o_mag (d_mag),
        .o_neg (d_neg),
        .o_dz  (d_dz)
    );

    // output stage: sign, zero divisor, idle zeroing
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_quot  <= '0;
        end else begin
            out_valid <= d_vld;
            if (!d_vld || d_dz) begin
                out_quot <= '0;
            end else if (d_neg) begin
                out_quot <= COEF_W'(-d_mag);
            end else begin
                out_quot <= d_mag;
            end
        end
    end
endmodule

// File: rtl/cq_chk.sv
module cq_chk #(
    parameter int COEF_W  = 12,
    parameter int IDX_W   = 6,
    parameter int BLK_LEN = 64,
    parameter int LATENCY = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [1:0]        comp_sel,
    input logic              out_valid,
    input logic [COEF_W-1:0] out_quot,
    input logic              busy,
    input logic [IDX_W-1:0]  beat_idx,
    input logic              blk_tbl
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(BLK_LEN - 1);

    logic [7:0] pend;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend <= '0;
        end else begin
            pend <= pend + 8'(in_valid) - 8'(out_valid);
        end
    end

    // R8
    out_has_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (pend != 8'd0));

    // R8
    inflight_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend <= 8'(LATENCY));

    // R9
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_quot == '0));

    // R2
    table_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !busy) |=> (busy && (blk_tbl == ($past(comp_sel) >= 2'd2))));

    // R3
    table_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(blk_tbl));

    // R4
    block_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && busy && beat_idx == LAST) |=> !busy);

    // R4
    beat_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && busy && beat_idx != LAST) |=> (busy && beat_idx == IDX_W'($past(beat_idx) + 1'b1)));
endmodule

bind coef_quantizer cq_chk #(
    .COEF_W  (COEF_W),
    .IDX_W   (IDX_W),
    .BLK_LEN (BLK_LEN),
    .LATENCY (LATENCY)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .comp_sel  (comp_sel),
    .out_valid (out_valid),
    .out_quot  (out_quot),
    .busy      (seq_busy),
    .beat_idx  (seq_idx),
    .blk_tbl   (seq_tbl_held)
);

// File: tb/tb_coef_quantizer.sv
module tb_coef_quantizer;
    localparam int LAT = 6;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic               rst_n;
    logic               in_valid;
    logic signed [11:0] in_coef;
    logic [1:0]         comp_sel;
    logic               out_valid;
    logic signed [11:0] out_quot;

    coef_quantizer dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_coef   (in_coef),
        .comp_sel  (comp_sel),
        .out_valid (out_valid),
        .out_quot  (out_quot)
    );

    int    checks = 0;
    int    fails  = 0;
    string cur_req = "R1";
    bit    cmp_on = 1'b0;

    // behavioural reference
    bit m_busy;
    int m_idx;
    int m_tbl;
    bit pv [LAT];
    int pq [LAT];

    function automatic int qtab(input int t, input int i);
        if (t == 0) return 4 * (i / 8) + 5 * (i % 8);   // R5
        return 17 * (i / 8) + 19 * (i % 8) + 1;
    endfunction

    function automatic int rdiv(input int a, input int d);
        int mag;
        int q;
        if (d == 0) return 0;                          // R7
        mag = (a < 0) ? -a : a;
        q   = (2 * mag + d) / (2 * d);                 // R6
        return (a < 0) ? -q : q;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 1'b0;
            m_idx  = 0;
            m_tbl  = 0;
            for (int k = 0; k < LAT; k++) begin
                pv[k] = 1'b0;
                pq[k] = 0;
            end
        end else begin
            for (int k = LAT - 1; k > 0; k--) begin
                pv[k] = pv[k-1];
                pq[k] = pq[k-1];
            end
            pv[0] = in_valid;
            pq[0] = 0;
            if (in_valid) begin
                if (!m_busy) begin
                    m_tbl  = (comp_sel >= 2) ? 1 : 0;
                    m_idx  = 0;
                    m_busy = 1'b1;
                end
                pq[0] = rdiv(int'(in_coef), qtab(m_tbl, m_idx));
                m_idx++;
                if (m_idx == 64) begin
                    m_busy = 1'b0;
                    m_idx  = 0;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (cmp_on && rst_n) begin
            checks++;
            if (out_valid !== pv[LAT-1] || int'(out_quot) != pq[LAT-1]) begin
                fails++;
                $display("FAIL %s: valid %0b quot %0d, expected valid %0b quot %0d",
                         cur_req, out_valid, out_quot, pv[LAT-1], pq[LAT-1]);
            end
        end
    end

    function automatic int coef_of(input int pat, input int i);
        case (pat)
            0: return (i == 2) ? 15 : ((i * 37) % 301) - 150;
            1: return (i == 2) ? -15 : 400 - ((i * 53) % 999);
            2: return (i % 2 == 0) ? -2048 : 2047;
            default: return (i == 2) ? 5 : (i - 32) * 3;
        endcase
    endfunction

    task automatic send_block(input logic [1:0] code, input int pat, input bit gaps);
        for (int i = 0; i < 64; i++) begin
            if (gaps && (i % 3 == 1)) begin
                @(negedge clk);
                in_valid = 1'b0;
                in_coef  = 12'sh5A5;
                comp_sel = ~code;
            end
            @(negedge clk);
            in_valid = 1'b1;
            in_coef  = 12'(coef_of(pat, i));
            comp_sel = (i == 0) ? code : (code ^ 2'b10);   // R3: mid-block changes
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_coef  = '0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R8: actual run still going, expected completion");
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        rst_n    = 1'b0;
        in_valid = 1'b0;
        in_coef  = '0;
        comp_sel = 2'd0;
        repeat (3) @(negedge clk);
        // R1: outputs held at zero in reset
        checks++;
        if (out_valid !== 1'b0 || out_quot !== 12'sd0) begin
            fails++;
            $display("FAIL R1: valid %0b quot %0d, expected valid 0 quot 0", out_valid, out_quot);
        end
        rst_n  = 1'b1;
        cmp_on = 1'b1;
        idle(2);

        cur_req = "R1 R2 R5 R6 R7 R9 (table 0, code 0)";
        send_block(2'd0, 0, 1'b0);
        idle(8);

        cur_req = "R2 R3 R8 R9 (table 1, code 3, gaps)";
        send_block(2'd3, 1, 1'b1);
        idle(8);

        cur_req = "R2 R4 (codes 1 then 2 back to back)";
        send_block(2'd1, 3, 1'b0);
        cur_req = "R2 R4 R6 (second block, code 2)";
        send_block(2'd2, 0, 1'b0);
        idle(8);

        cur_req = "R10 (extremes, table 0)";
        send_block(2'd1, 2, 1'b1);
        cur_req = "R10 (extremes, table 1)";
        send_block(2'd2, 2, 1'b0);
        idle(10);

        cmp_on = 1'b0;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule